// File: doc/BRIEF.md
# PSRAM Mode Register File

This block is the configuration store on the device side of an octal DDR pseudo-static RAM model. The command decoder hands it register read and register write requests, each with an 8-bit register address and 8-bit data. It holds three writable configuration registers, three identification registers that can only be read, and one command register that can only be written. From the stored fields it derives registered configuration outputs that the rest of the model uses: the read wait in clock cycles, the latency type, the write wait in cycles, the burst type and length, the data width mode and row-crossing permission.

Writing the command register arms one of two power modes, a data-retaining half sleep or a deep power down. Nothing changes until chip select next returns high. From then the mode holds until chip select is pulsed low again. Leaving deep power down restores every register to its power-on value. Leaving half sleep keeps the registers as they were. A global reset request restores every register and drops any armed mode. Drive strength is stored and read back but drives nothing.

Top module: `psram_mode_regs`

## Requirements
- R1: After reset, register 0 reads 08h, register 4 reads 40h and register 8 reads 05h. The outputs then read: rd_wait=5, lat_fixed=0, wr_wait=5, burst_hybrid=1, burst_len=32, x16_mode=0, rbx_en=0, half_sleep=0, deep_pd=0.
- R2: Register 1 reads 8Dh: bit 7 is low-power support=1 and bits 4:0 are the vendor code 01101. Register 2 reads DFh: bits 7:5 are the good-die code 110, bits 4:3 are 11 and bits 2:0 are the density code 111. Register 3 reads {1, 0, refresh_rate[1:0], 0000}.
- R3: A write to register 1, 2 or 3, or to any address other than 0, 4, 6 and 8, changes nothing. A read of register 6 or of any undefined address returns 00h.
- R4: A read request is answered on the next cycle, with rdata valid and rd_valid high for one cycle.
- R5: Register 0 bits 4:2 select the read latency: codes 000, 001, 010, 011 and 100 give 3, 4, 5, 6 and 7 cycles, and codes 101 to 111 give 7. With bit 5 = 0 (variable), rd_wait equals that latency. With bit 5 = 1 (fixed), rd_wait is twice the latency and lat_fixed=1.
- R6: Register 4 bits 7:5 select the write latency: code 000 gives 3 cycles, 100 gives 4, 010 gives 5, 110 gives 6 and 001 gives 7. Any other code gives 7.
- R7: Register 8 bits 1:0 set burst_len: 00 gives 16, 01 gives 32, 10 gives 64, and 11 gives a full page (2048 in x8 mode, 1024 in x16 mode). The other fields of register 8 are bit 2 (burst_hybrid), bit 3 (rbx_en) and bit 6 (x16_mode).
- R8: Register 0 bits 7:6 and register 8 bit 7 always store 0, whatever is written to them. Register 0 bits 1:0 (drive strength) store and read back as written.
- R9: Writing F0h to register 6 arms half sleep. The mode is entered on the next rising edge of cs_n and left on the next falling edge. Register contents are kept through it.
- R10: Writing C0h to register 6 arms deep power down. The mode is entered on the next rising edge of cs_n. The next falling edge of cs_n leaves the mode and restores all registers to their reset values.
- R11: Writing any other value to register 6 cancels an armed mode, so the following cs_n rising edge enters no mode.
- R12: A glb_rst pulse restores all registers to their reset values and cancels an armed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (reset pin) |
| glb_rst | input | 1 | Global reset command pulse |
| cs_n | input | 1 | Chip select, active low |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| refresh_rate | input | 2 | Current refresh rate reported in register 3 |
| rdata | output | 8 | Register read data |
| rd_valid | output | 1 | rdata valid |
| rd_wait | output | 4 | Effective read wait in cycles |
| lat_fixed | output | 1 | Fixed read latency selected |
| wr_wait | output | 3 | Write wait in cycles |
| burst_hybrid | output | 1 | Hybrid burst selected |
| burst_len | output | 12 | Burst length in transfer units |
| x16_mode | output | 1 | 16-bit data mode |
| rbx_en | output | 1 | Row-boundary crossing allowed on linear reads |
| half_sleep | output | 1 | Half sleep mode active |
| deep_pd | output | 1 | Deep power down active |

## Verification
The assertions assume that reg_wr and reg_rd come from one command decoder and so never ask for more than one request per cycle. They also assume that glb_rst is a one-cycle pulse and that cs_n changes only once per cycle. The stimulus drives every input on the falling clock edge and raises each request for exactly one cycle. It moves cs_n only between requests, so mode entry and exit come from a single clean edge of cs_n.

// File: rtl/psram_mr_pkg.sv
package psram_mr_pkg;

  localparam int unsigned MR_W = 8;

  localparam logic [7:0] A_CFG0 = 8'h00;
  localparam logic [7:0] A_ID1  = 8'h01;
  localparam logic [7:0] A_ID2  = 8'h02;
  localparam logic [7:0] A_STAT = 8'h03;
  localparam logic [7:0] A_CFG4 = 8'h04;
  localparam logic [7:0] A_PWR  = 8'h06;
  localparam logic [7:0] A_CFG8 = 8'h08;

  localparam logic [7:0] CFG0_RST = 8'h08;
  localparam logic [7:0] CFG4_RST = 8'h40;
  localparam logic [7:0] CFG8_RST = 8'h05;

  localparam logic [7:0] PWR_HSLEEP = 8'hF0;
  localparam logic [7:0] PWR_DEEP   = 8'hC0;

  typedef enum logic [1:0] {ARM_NONE, ARM_HS, ARM_DPD} arm_e;

  function automatic logic [3:0] rd_lat_of(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd3;
      3'b001:  return 4'd4;
      3'b010:  return 4'd5;
      3'b011:  return 4'd6;
      default: return 4'd7;
    endcase
  endfunction

  function automatic logic [2:0] wr_lat_of(input logic [2:0] code);
    case (code)
      3'b000:  return 3'd3;
      3'b100:  return 3'd4;
      3'b010:  return 3'd5;
      3'b110:  return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/mr_cfg_decode.sv
module mr_cfg_decode
  import psram_mr_pkg::*;
#(
  parameter int unsigned COL_W = 11,
  parameter int unsigned LAT_W = 4,
  parameter int unsigned WL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MR_W-1:0]  cfg0,
  input  logic [MR_W-1:0]  cfg4,
  input  logic [MR_W-1:0]  cfg8,
  output logic [LAT_W-1:0] rd_wait,
  output logic             lat_fixed,
  output logic [WL_W-1:0]  wr_wait,
  output logic             burst_hybrid,
  output logic [COL_W:0]   burst_len,
  output logic             x16_mode,
  output logic             rbx_en
);
  localparam int unsigned BL_W = COL_W + 1;
  localparam logic [BL_W-1:0] PAGE_X8  = BL_W'(1) << COL_W;
  localparam logic [BL_W-1:0] PAGE_X16 = BL_W'(1) << (COL_W - 1);

  logic [LAT_W-1:0] lat_n;
  logic [BL_W-1:0]  len_n;

  always_comb begin
    lat_n = LAT_W'(rd_lat_of(cfg0[4:2]));
    if (cfg0[5]) lat_n = lat_n << 1;
    case (cfg8[1:0])
      2'b00:   len_n = BL_W'(16);
      2'b01:   len_n = BL_W'(32);
      2'b10:   len_n = BL_W'(64);
      default: len_n = cfg8[6] ? PAGE_X16 : PAGE_X8;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_wait      <= LAT_W'(5);
      lat_fixed    <= 1'b0;
      wr_wait      <= WL_W'(5);
      burst_hybrid <= 1'b1;
      burst_len    <= BL_W'(32);
      x16_mode     <= 1'b0;
      rbx_en       <= 1'b0;
    end else begin
      rd_wait      <= lat_n;
      lat_fixed    <= cfg0[5];
      wr_wait      <= WL_W'(wr_lat_of(cfg4[7:5]));
      burst_hybrid <= cfg8[2];
      burst_len    <= len_n;
      x16_mode     <= cfg8[6];
      rbx_en       <= cfg8[3];
    end
  end

  // R5
  fixed_even_chk: assert property (@(posedge clk) disable iff (rst)
    lat_fixed |-> (rd_wait[0] == 1'b0 && rd_wait >= LAT_W'(6)));

  // R7
  page_len_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(burst_len) == 1);

endmodule

// File: rtl/mr_power_ctl.sv
module mr_power_ctl
  import psram_mr_pkg::*;
#(
  parameter int unsigned DW = MR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          glb_rst,
  input  logic          cs_n,
  input  logic          pwr_wr,
  input  logic [DW-1:0] pwr_data,
  output logic          half_sleep,
  output logic          deep_pd,
  output logic          dpd_clr
);
  arm_e armed;
  logic cs_q;
  logic cs_rise, cs_fall;

  assign cs_rise = cs_n & ~cs_q;
  assign cs_fall = ~cs_n & cs_q;

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b1;
    else     cs_q <= cs_n;
  end

  always_ff @(posedge clk) begin
    if (rst || glb_rst) begin
      armed      <= ARM_NONE;
      half_sleep <= 1'b0;
      deep_pd    <= 1'b0;
      dpd_clr    <= 1'b0;
    end else begin
      dpd_clr <= 1'b0;
      if (pwr_wr) begin
        if (pwr_data == DW'(PWR_HSLEEP))    armed <= ARM_HS;
        else if (pwr_data == DW'(PWR_DEEP)) armed <= ARM_DPD;
        else                                armed <= ARM_NONE;
      end else if (cs_rise && armed != ARM_NONE) begin
        half_sleep <= (armed == ARM_HS);
        deep_pd    <= (armed == ARM_DPD);
        armed      <= ARM_NONE;
      end else if (cs_fall && (half_sleep || deep_pd)) begin
        half_sleep <= 1'b0;
        deep_pd    <= 1'b0;
        dpd_clr    <= deep_pd;
      end
    end
  end

  // R9
  one_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({half_sleep, deep_pd}));

  // R9
  hs_entry_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(half_sleep) |-> (cs_q && !$past(cs_q)));

  // R10
  dpd_entry_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(deep_pd) |-> (cs_q && !$past(cs_q)));

endmodule

// File: rtl/psram_mode_regs.sv
module psram_mode_regs
  import psram_mr_pkg::*;
#(
  parameter int unsigned COL_W    = 11,
  parameter logic [4:0]  VENDOR   = 5'b01101,
  parameter logic [2:0]  DENSITY  = 3'b111,
  parameter logic [1:0]  GEN      = 2'b11,
  parameter logic [2:0]  DIE_OK   = 3'b110
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         glb_rst,
  input  logic         cs_n,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [7:0]   reg_addr,
  input  logic [7:0]   reg_wdata,
  input  logic [1:0]   refresh_rate,
  output logic [7:0]   rdata,
  output logic         rd_valid,
  output logic [3:0]   rd_wait,
  output logic         lat_fixed,
  output logic [2:0]   wr_wait,
  output logic         burst_hybrid,
  output logic [COL_W:0] burst_len,
  output logic         x16_mode,
  output logic         rbx_en,
  output logic         half_sleep,
  output logic         deep_pd
);
  logic [MR_W-1:0] cfg0_q, cfg4_q, cfg8_q;
  logic [MR_W-1:0] rd_mux;
  logic            dpd_clr;
  logic            clr;
  logic            pwr_wr;

  assign clr    = rst | glb_rst | dpd_clr;
  assign pwr_wr = reg_wr && (reg_addr == A_PWR);

  always_ff @(posedge clk) begin
    if (clr) begin
      cfg0_q <= CFG0_RST;
      cfg4_q <= CFG4_RST;
      cfg8_q <= CFG8_RST;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CFG0:  cfg0_q <= {2'b00, reg_wdata[5:0]};
        A_CFG4:  cfg4_q <= reg_wdata;
        A_CFG8:  cfg8_q <= {1'b0, reg_wdata[6:0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG0:  rd_mux = cfg0_q;
      A_ID1:   rd_mux = {1'b1, 2'b00, VENDOR};
      A_ID2:   rd_mux = {DIE_OK, GEN, DENSITY};
      A_STAT:  rd_mux = {1'b1, 1'b0, refresh_rate, 4'b0000};
      A_CFG4:  rd_mux = cfg4_q;
      A_CFG8:  rd_mux = cfg8_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rdata <= rd_mux;
    end
  end

  mr_cfg_decode #(.COL_W(COL_W), .LAT_W(4), .WL_W(3)) u_dec (
    .clk(clk), .rst(rst), .cfg0(cfg0_q), .cfg4(cfg4_q), .cfg8(cfg8_q),
    .rd_wait(rd_wait), .lat_fixed(lat_fixed), .wr_wait(wr_wait),
    .burst_hybrid(burst_hybrid), .burst_len(burst_len),
    .x16_mode(x16_mode), .rbx_en(rbx_en)
  );

  mr_power_ctl #(.DW(MR_W)) u_pwr (
    .clk(clk), .rst(rst), .glb_rst(glb_rst), .cs_n(cs_n),
    .pwr_wr(pwr_wr), .pwr_data(reg_wdata),
    .half_sleep(half_sleep), .deep_pd(deep_pd), .dpd_clr(dpd_clr)
  );

  // R4
  rd_answer_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> rd_valid);

  // R8
  zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg0_q[7:6] == 2'b00) && (cfg8_q[7] == 1'b0));

  // R10
  dpd_exit_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(deep_pd) |=> (cfg0_q == CFG0_RST && cfg4_q == CFG4_RST && cfg8_q == CFG8_RST));

  // R12
  glb_clr_chk: assert property (@(posedge clk) disable iff (rst)
    glb_rst |=> (cfg0_q == CFG0_RST && cfg4_q == CFG4_RST && cfg8_q == CFG8_RST
                 && !half_sleep && !deep_pd));

endmodule

// File: tb/sim_psram_mode_regs.sv
module sim_psram_mode_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_rst = 1'b0;
  logic cs_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [1:0] refresh_rate = 2'b10;
  logic [7:0] rdata;
  logic rd_valid;
  logic [3:0] rd_wait;
  logic lat_fixed;
  logic [2:0] wr_wait;
  logic burst_hybrid;
  logic [11:0] burst_len;
  logic x16_mode, rbx_en, half_sleep, deep_pd;

  int checks = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  psram_mode_regs u0 (
    .clk(clk), .rst(rst), .glb_rst(glb_rst), .cs_n(cs_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .refresh_rate(refresh_rate), .rdata(rdata), .rd_valid(rd_valid),
    .rd_wait(rd_wait), .lat_fixed(lat_fixed), .wr_wait(wr_wait),
    .burst_hybrid(burst_hybrid), .burst_len(burst_len), .x16_mode(x16_mode),
    .rbx_en(rbx_en), .half_sleep(half_sleep), .deep_pd(deep_pd)
  );

  // {addr, wdata, readback, rd_wait, wr_wait, burst_len}
  localparam int NV = 18;
  localparam logic [43:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 4'd3,  4'd5, 12'd32},
    {8'h00, 8'h04, 8'h04, 4'd4,  4'd5, 12'd32},
    {8'h00, 8'h0C, 8'h0C, 4'd6,  4'd5, 12'd32},
    {8'h00, 8'h10, 8'h10, 4'd7,  4'd5, 12'd32},
    {8'h00, 8'h14, 8'h14, 4'd7,  4'd5, 12'd32},
    {8'h00, 8'h2B, 8'h2B, 4'd10, 4'd5, 12'd32},
    {8'h00, 8'hC8, 8'h08, 4'd5,  4'd5, 12'd32},
    {8'h04, 8'h00, 8'h00, 4'd5,  4'd3, 12'd32},
    {8'h04, 8'h80, 8'h80, 4'd5,  4'd4, 12'd32},
    {8'h04, 8'hC0, 8'hC0, 4'd5,  4'd6, 12'd32},
    {8'h04, 8'h20, 8'h20, 4'd5,  4'd7, 12'd32},
    {8'h04, 8'h60, 8'h60, 4'd5,  4'd7, 12'd32},
    {8'h04, 8'h5B, 8'h5B, 4'd5,  4'd5, 12'd32},
    {8'h08, 8'h00, 8'h00, 4'd5,  4'd5, 12'd16},
    {8'h08, 8'h02, 8'h02, 4'd5,  4'd5, 12'd64},
    {8'h08, 8'h03, 8'h03, 4'd5,  4'd5, 12'd2048},
    {8'h08, 8'h43, 8'h43, 4'd5,  4'd5, 12'd1024},
    {8'h08, 8'h8D, 8'h0D, 4'd5,  4'd5, 12'd32}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = rdata; v = rd_valid;
  endtask

  task automatic defaults_chk(input string tag);
    logic [7:0] d; logic v;
    rd(8'h00, d, v); chk({tag, " cfg0"}, d, 8'h08);
    rd(8'h04, d, v); chk({tag, " cfg4"}, d, 8'h40);
    rd(8'h08, d, v); chk({tag, " cfg8"}, d, 8'h05);
    chk({tag, " rd_wait"}, rd_wait, 5);
    chk({tag, " wr_wait"}, wr_wait, 5);
    chk({tag, " burst_len"}, burst_len, 32);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 lat_fixed", lat_fixed, 0);
    chk("R1 hybrid", burst_hybrid, 1);
    chk("R1 x16", x16_mode, 0);
    chk("R1 rbx", rbx_en, 0);
    chk("R1 modes", {half_sleep, deep_pd}, 0);
    defaults_chk("R1");

    // R2 identification registers
    rd(8'h01, d, v); chk("R2 id1", d, 8'h8D);
    rd(8'h02, d, v); chk("R2 id2", d, 8'hDF);
    rd(8'h03, d, v); chk("R2 stat rate10", d, 8'hA0);
    refresh_rate = 2'b01;
    rd(8'h03, d, v); chk("R2 stat rate01", d, 8'h90);

    // R4 read handshake timing
    @(negedge clk); reg_rd = 1'b1; reg_addr = 8'h01;
    chk("R4 valid low before edge", rd_valid, 0);
    @(negedge clk); reg_rd = 1'b0;
    chk("R4 valid", rd_valid, 1); chk("R4 data", rdata, 8'h8D);
    @(negedge clk);
    chk("R4 valid one cycle", rd_valid, 0);

    // R5 R6 R7 R8 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][43:36], VEC[i][35:28]);
      rd(VEC[i][43:36], d, v);
      chk($sformatf("R8 readback vec%0d", i), d, VEC[i][27:20]);
      chk($sformatf("R5 rd_wait vec%0d", i), rd_wait, VEC[i][19:16]);
      chk($sformatf("R6 wr_wait vec%0d", i), wr_wait, VEC[i][14:12]);
      chk($sformatf("R7 burst_len vec%0d", i), burst_len, VEC[i][11:0]);
    end
    // R7 flags from 0Dh in register 8
    chk("R7 hybrid", burst_hybrid, 1);
    chk("R7 rbx", rbx_en, 1);
    chk("R7 x16 off", x16_mode, 0);
    wr(8'h08, 8'h40);
    chk("R7 x16 on", x16_mode, 1);
    chk("R7 hybrid off", burst_hybrid, 0);
    // R5 fixed flag
    wr(8'h00, 8'h20);
    chk("R5 lat_fixed", lat_fixed, 1);
    chk("R5 fixed doubled", rd_wait, 6);

    // R3 ignored writes and empty reads
    wr(8'h01, 8'h00); rd(8'h01, d, v); chk("R3 id1 kept", d, 8'h8D);
    wr(8'h05, 8'hFF); rd(8'h00, d, v); chk("R3 cfg0 kept", d, 8'h20);
    rd(8'h04, d, v); chk("R3 cfg4 kept", d, 8'h5B);
    rd(8'h08, d, v); chk("R3 cfg8 kept", d, 8'h40);
    rd(8'h06, d, v); chk("R3 pwr reads zero", d, 8'h00);
    rd(8'h07, d, v); chk("R3 undefined reads zero", d, 8'h00);

    // R9 half sleep
    wr(8'h06, 8'hF0);
    chk("R9 not before cs rise", half_sleep, 0);
    cs_n = 1'b1; @(negedge clk);
    chk("R9 entered", half_sleep, 1);
    chk("R9 no dpd", deep_pd, 0);
    cs_n = 1'b0; @(negedge clk);
    chk("R9 left", half_sleep, 0);
    rd(8'h00, d, v); chk("R9 retained", d, 8'h20);

    // R11 cancel
    wr(8'h06, 8'hF0); wr(8'h06, 8'h55);
    cs_n = 1'b1; @(negedge clk); @(negedge clk);
    chk("R11 no mode", {half_sleep, deep_pd}, 0);
    cs_n = 1'b0; @(negedge clk);

    // R10 deep power down
    wr(8'h06, 8'hC0);
    cs_n = 1'b1; @(negedge clk);
    chk("R10 entered", deep_pd, 1);
    rd(8'h00, d, v); chk("R10 kept while down", d, 8'h20);
    cs_n = 1'b0; @(negedge clk);
    chk("R10 left", deep_pd, 0);
    @(negedge clk); @(negedge clk);
    chk("R10 lat_fixed cleared", lat_fixed, 0);
    defaults_chk("R10");

    // R12 global reset
    wr(8'h00, 8'h3F); wr(8'h04, 8'hC0); wr(8'h08, 8'h4B);
    wr(8'h06, 8'hF0);
    @(negedge clk); glb_rst = 1'b1;
    @(negedge clk); glb_rst = 1'b0;
    @(negedge clk);
    defaults_chk("R12");
    cs_n = 1'b1; @(negedge clk); @(negedge clk);
    chk("R12 arm cleared", {half_sleep, deep_pd}, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule